// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block buffers 18-bit words between two independent clock domains. The writer and the reader may run on unrelated clocks or on the same clock. Its capacity is 512 words. On the write side, two enables of opposite polarity qualify each write, and an input-ready flag in the write domain reports whether there is room. On the read side, the output register shows the oldest word as soon as that word has crossed into the read domain. An output-ready flag in the read domain marks that word as valid. A consumer takes the word by pulling its read enable and both output enables low.

Two level flags in the write domain report the fill. Half-full is set when more than half of the capacity is in use. The almost flag is set when the FIFO is close to empty or close to full, within an offset that is captured while reset is asserted. One active-low reset clears the pointers, the synchronizer chains and the flags in both domains. Reset is asynchronous, and it must be held across at least four rising edges of each clock.

Top module: `dual_clock_fwft_fifo`

## Requirements
- R1: Words leave the FIFO in the order they were accepted, with their 18-bit values unchanged, and up to 512 of them are held at once.
- R2: A write happens on a rising wclk edge only when wr_en_hi is 1, wr_en_lo_n is 0 and in_ready is 1. Any other combination stores nothing.
- R3: A read happens on a rising rclk edge only when rd_en_n, oe_a_n and oe_b_n are all 0 and out_ready is 1. While a read is withheld, out_ready stays 1 and rd_data keeps its value.
- R4: A word written into an empty FIFO reaches rd_data and raises out_ready without any read request, whatever the levels of rd_en_n, oe_a_n and oe_b_n.
- R5: The fill count includes the word held in the output register. in_ready is 0 while that count is 512, and it returns to 1 once reads have freed space and the read pointer has crossed into the write domain.
- R6: If a read is accepted while more words are waiting, the next word is loaded on the same edge and out_ready stays 1. If no word is waiting, out_ready falls to 0 after that edge.
- R7: While rst_n is 0, in_ready, out_ready and half_full are 0 and almost_flag is 1.
- R8: half_full is 1 exactly when the fill count is 257 or more.
- R9: almost_flag is 1 exactly when the fill count is at most the offset or at least 512 minus the offset.
- R10: The offset is taken from almost_ofs while rst_n is 0. Changes to almost_ofs after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wr_en_hi | input | 1 | Write qualifier, active high |
| wr_en_lo_n | input | 1 | Write qualifier, active low |
| wr_data | input | 18 | Word to store |
| in_ready | output | 1 | Room available (write domain) |
| rclk | input | 1 | Read-domain clock |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| rd_data | output | 18 | Head word in the output register |
| out_ready | output | 1 | rd_data holds a valid word (read domain) |
| rst_n | input | 1 | Asynchronous reset, active low |
| almost_ofs | input | 9 | Almost-flag offset, captured during reset |
| half_full | output | 1 | Fill count is 257 or more (write domain) |
| almost_flag | output | 1 | Fill count is near empty or near full (write domain) |

## Verification
The first pattern writes one isolated word while every read enable is off. This shows whether the fall-through path works on its own and whether a single disabled output enable blocks the read. A fill done one word at a time lets the flags be checked on both sides of each threshold (8/9, 256/257, 503/504 and 512), and a full drain at full rate then checks that the output register refills with no gaps. A long stretch of random writes and reads, including illegal enable pairs, is run on clocks with unrelated periods and compared against an order-preserving scoreboard, which separates pointer-crossing faults from qualifier faults. A second reset with a small offset, followed by a change to the offset input, checks that the threshold is captured only during reset.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  typedef logic [31:0] word32_t;

  function automatic word32_t to_gray(word32_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic word32_t from_gray(word32_t g);
    word32_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic over_half(word32_t cnt, word32_t depth);
    return cnt > (depth >> 1);
  endfunction

  function automatic logic near_edge(word32_t cnt, word32_t ofs, word32_t depth);
    return (cnt <= ofs) || (cnt >= depth - ofs);
  endfunction
endpackage

// File: rtl/xfifo_gsync.sv
module xfifo_gsync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q_r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q_r <= '0;
        else        q_r <= g_stage[s-1].q_r;
    end
  end
  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk)
    if (we) cells[waddr] <= wdata;

  assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          we_hi,
  input  logic          we_lo_n,
  input  logic [AW-1:0] ofs_in,
  input  logic [PW-1:0] rcons_gray_s,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wptr_gray,
  output logic          in_ready,
  output logic          half_full,
  output logic          almost
);
  logic [PW-1:0] wbin, wbin_nxt, rcons_bin, fill_nxt;
  logic [AW-1:0] ofs_q;

  assign wr_fire   = in_ready && we_hi && !we_lo_n;
  assign wbin_nxt  = wbin + PW'(wr_fire);
  assign rcons_bin = PW'(from_gray(32'(rcons_gray_s)));
  assign fill_nxt  = wbin_nxt - rcons_bin;
  assign wr_addr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin      <= '0;
      wptr_gray <= '0;
      in_ready  <= 1'b0;
      half_full <= 1'b0;
      almost    <= 1'b1;
      ofs_q     <= ofs_in;
    end else begin
      wbin      <= wbin_nxt;
      wptr_gray <= PW'(to_gray(32'(wbin_nxt)));
      in_ready  <= fill_nxt != PW'(DEPTH);
      half_full <= over_half(32'(fill_nxt), 32'(DEPTH));
      almost    <= near_edge(32'(fill_nxt), 32'(ofs_q), 32'(DEPTH));
    end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |-> ((wbin - rcons_bin) < PW'(DEPTH))); // R5
  AST_READY_FALLS_ON_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(wr_fire)); // R5
  AST_HALF_RISES_ON_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(half_full) |-> $past(wr_fire)); // R8
  AST_ALMOST_WHEN_DRY: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin == rcons_bin && !wr_fire) |=> almost); // R9
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int DW    = 18,
  parameter int AW    = 9,
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic [PW-1:0] wptr_gray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rcons_gray,
  output logic          out_ready,
  output logic [DW-1:0] rd_data
);
  logic [PW-1:0] fbin, cbin, cbin_nxt, wbin_s;
  logic          avail, rd_take, load;

  assign wbin_s   = PW'(from_gray(32'(wptr_gray_s)));
  assign avail    = wbin_s != fbin;
  assign rd_take  = out_ready && !ren_n && !oe_a_n && !oe_b_n;
  assign load     = avail && (!out_ready || rd_take);
  assign cbin_nxt = cbin + PW'(rd_take);
  assign rd_addr  = fbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      fbin       <= '0;
      cbin       <= '0;
      rcons_gray <= '0;
      out_ready  <= 1'b0;
      rd_data    <= '0;
    end else begin
      cbin       <= cbin_nxt;
      rcons_gray <= PW'(to_gray(32'(cbin_nxt)));
      out_ready  <= load || (out_ready && !rd_take);
      if (load) begin
        rd_data <= mem_q;
        fbin    <= fbin + 1'b1;
      end
    end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_ready && !rd_take) |=> (out_ready && $stable(rd_data))); // R3
  AST_FALL_THROUGH: assert property (@(posedge rclk) disable iff (!rst_n)
    (!out_ready && avail) |=> out_ready); // R4
  AST_REFILL_SAME_EDGE: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_take && avail) |=> out_ready); // R6
  AST_DROP_WHEN_DRY: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_take && !avail) |=> !out_ready); // R6
endmodule

// File: rtl/dual_clock_fwft_fifo.sv
module dual_clock_fwft_fifo #(
  parameter int DW     = 18,
  parameter int DEPTH  = 512,
  parameter int SYNC   = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          wr_en_hi,
  input  logic          wr_en_lo_n,
  input  logic [DW-1:0] wr_data,
  output logic          in_ready,
  input  logic          rclk,
  input  logic          rd_en_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  output logic [DW-1:0] rd_data,
  output logic          out_ready,
  input  logic          rst_n,
  input  logic [AW-1:0] almost_ofs,
  output logic          half_full,
  output logic          almost_flag
);
  logic          wr_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wptr_gray, wptr_gray_s, rcons_gray, rcons_gray_s;
  logic [DW-1:0] mem_q;

  xfifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .wclk(wclk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_q));

  xfifo_wside #(.DEPTH(DEPTH), .AW(AW)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .we_hi(wr_en_hi), .we_lo_n(wr_en_lo_n),
    .ofs_in(almost_ofs), .rcons_gray_s(rcons_gray_s), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wptr_gray(wptr_gray), .in_ready(in_ready),
    .half_full(half_full), .almost(almost_flag));

  xfifo_gsync #(.W(PW), .STAGES(SYNC)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wptr_gray), .q(wptr_gray_s));

  xfifo_gsync #(.W(PW), .STAGES(SYNC)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rcons_gray), .q(rcons_gray_s));

  xfifo_rside #(.DW(DW), .AW(AW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .ren_n(rd_en_n), .oe_a_n(oe_a_n),
    .oe_b_n(oe_b_n), .wptr_gray_s(wptr_gray_s), .mem_q(mem_q),
    .rd_addr(rd_addr), .rcons_gray(rcons_gray), .out_ready(out_ready),
    .rd_data(rd_data));
endmodule

// File: tb/dual_clock_fwft_fifo_test.sv
module dual_clock_fwft_fifo_test;
  localparam int DW = 18, DEPTH = 512, AW = 9;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic we_hi = 0, we_lo_n = 1;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] ofs = 9'd8;
  logic ren_n = 1, oea_n = 1, oeb_n = 1;
  wire ir, orr, hf, af;
  wire [DW-1:0] rdata;

  int tests = 0, fails = 0, reads_seen = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] mon_e;
  bit done = 0;

  dual_clock_fwft_fifo uut (
    .wclk(wclk), .wr_en_hi(we_hi), .wr_en_lo_n(we_lo_n), .wr_data(wdata),
    .in_ready(ir), .rclk(rclk), .rd_en_n(ren_n), .oe_a_n(oea_n),
    .oe_b_n(oeb_n), .rd_data(rdata), .out_ready(orr), .rst_n(rst_n),
    .almost_ofs(ofs), .half_full(hf), .almost_flag(af));

  always #4 wclk = ~wclk;
  always #6 rclk = ~rclk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pushes a word into the model when the write will be taken
  task automatic wr_cycle(logic e1, logic e2n, logic [DW-1:0] d);
    @(posedge wclk); #1;
    we_hi = e1; we_lo_n = e2n; wdata = d;
    @(negedge wclk);
    if (e1 && !e2n && ir === 1'b1) exp_q.push_back(d);
  endtask

  task automatic put(logic [DW-1:0] d);
    wr_cycle(1'b1, 1'b0, d);
    wr_cycle(1'b0, 1'b1, '0);
  endtask

  task automatic rd_cycle(logic r, logic a, logic b);
    @(posedge rclk); #1;
    ren_n = r; oea_n = a; oeb_n = b;
  endtask

  // monitor: compares every accepted read against the model
  always @(negedge rclk)
    if (rst_n && orr === 1'b1 && !ren_n && !oea_n && !oeb_n) begin
      reads_seen++;
      if (exp_q.size() == 0) check("R1 read with empty model", 32'd1, 32'd0);
      else begin
        mon_e = exp_q.pop_front();
        check("R1 data order", 32'(rdata), 32'(mon_e));
      end
    end

  task automatic do_reset(logic [AW-1:0] o);
    rst_n = 0; ofs = o;
    we_hi = 0; we_lo_n = 1; ren_n = 1; oea_n = 1; oeb_n = 1;
    repeat (5) @(posedge rclk);
    exp_q.delete();
    #1;
    check("R7 in_ready in reset", 32'(ir), 32'd0);
    check("R7 out_ready in reset", 32'(orr), 32'd0);
    check("R7 half_full in reset", 32'(hf), 32'd0);
    check("R7 almost in reset", 32'(af), 32'd1);
    @(negedge wclk); rst_n = 1;
    repeat (3) @(negedge wclk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int gaps;
    do_reset(9'd8);
    check("R5 in_ready after reset", 32'(ir), 32'd1);
    check("R9 almost at empty", 32'(af), 32'd1);

    // R2: illegal enable pairs store nothing
    wr_cycle(1'b0, 1'b0, 18'h15555);
    wr_cycle(1'b1, 1'b1, 18'h2aaaa);
    wr_cycle(1'b0, 1'b1, 18'h00000);
    repeat (10) @(negedge rclk);
    check("R2 ignored writes leave FIFO empty", 32'(orr), 32'd0);
    check("R2 ignored writes leave almost high", 32'(af), 32'd1);

    // R4 / R3: fall-through with all reads disabled, then partial enables
    put(18'h3c0de);
    repeat (8) @(negedge rclk);
    check("R4 out_ready without request", 32'(orr), 32'd1);
    check("R4 head word visible", 32'(rdata), 32'h3c0de);
    rd_cycle(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge rclk);
    check("R3 oe_a_n high blocks read", 32'(orr), 32'd1);
    check("R3 data held", 32'(rdata), 32'h3c0de);
    rd_cycle(1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge rclk);
    check("R3 oe_b_n high blocks read", 32'(orr), 32'd1);
    rd_cycle(1'b0, 1'b0, 1'b0);
    rd_cycle(1'b1, 1'b1, 1'b1);
    @(negedge rclk);
    check("R6 out_ready drops after last word", 32'(orr), 32'd0);
    check("R1 model drained", exp_q.size(), 32'd0);
    repeat (6) @(negedge wclk);

    // fill one word at a time, checking thresholds
    for (int i = 1; i <= DEPTH; i++) begin
      put(18'(i * 37 + 5));
      if (i == 8)   check("R9 almost at count 8", 32'(af), 32'd1);
      if (i == 9)   check("R9 almost at count 9", 32'(af), 32'd0);
      if (i == 256) check("R8 half at count 256", 32'(hf), 32'd0);
      if (i == 257) check("R8 half at count 257", 32'(hf), 32'd1);
      if (i == 503) check("R9 almost at count 503", 32'(af), 32'd0);
      if (i == 504) check("R9 almost at count 504", 32'(af), 32'd1);
      if (i == 511) check("R5 ready at count 511", 32'(ir), 32'd1);
    end
    check("R5 ready low when full", 32'(ir), 32'd0);
    check("R8 half when full", 32'(hf), 32'd1);
    put(18'h1ffff);  // refused: model does not take it
    check("R5 extra write refused", exp_q.size(), 32'd512);

    // full-rate drain
    gaps = 0;
    rd_cycle(1'b0, 1'b0, 1'b0);
    repeat (DEPTH) begin
      @(negedge rclk);
      if (orr !== 1'b1) gaps++;
    end
    rd_cycle(1'b1, 1'b1, 1'b1);
    check("R6 no gap during drain", gaps, 32'd0);
    @(negedge rclk);
    check("R6 out_ready low after drain", 32'(orr), 32'd0);
    check("R1 drain matched all words", exp_q.size(), 32'd0);
    repeat (6) @(negedge wclk);
    check("R5 ready back after drain", 32'(ir), 32'd1);
    check("R8 half clear after drain", 32'(hf), 32'd0);
    check("R9 almost after drain", 32'(af), 32'd1);

    // random concurrent traffic
    fork
      begin
        logic [31:0] s = 32'h1234_5678;
        for (int k = 0; k < 2000; k++) begin
          s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
          wr_cycle(s[0] | s[1], s[2] & s[3], s[DW+4:5]);
        end
        wr_cycle(1'b0, 1'b1, '0);
      end
      begin
        logic [31:0] t = 32'h9e37_79b9;
        for (int k = 0; k < 1400; k++) begin
          t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
          rd_cycle(t[0] & t[1], t[2] & t[3] & t[4], t[5] & t[6] & t[7]);
        end
      end
    join
    rd_cycle(1'b0, 1'b0, 1'b0);
    repeat (DEPTH + 20) @(negedge rclk);
    rd_cycle(1'b1, 1'b1, 1'b1);
    @(negedge rclk);
    check("R1 random traffic fully matched", exp_q.size(), 32'd0);
    check("R6 out_ready low at end", 32'(orr), 32'd0);

    // R10: offset captured at reset only
    do_reset(9'd3);
    ofs = 9'd20;
    put(18'h1); put(18'h2); put(18'h3);
    check("R10 almost at count 3 with offset 3", 32'(af), 32'd1);
    put(18'h4);
    check("R10 almost at count 4 ignores new offset", 32'(af), 32'd0);
    rd_cycle(1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge rclk);
    rd_cycle(1'b1, 1'b1, 1'b1);
    @(negedge rclk);
    check("R1 short run matched", exp_q.size(), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule